// File: doc/BRIEF.md
# SPI Flash Erase Sequencer

This block clears a byte range of a page-organized serial flash by issuing erase commands over a byte-level SPI master port. A request supplies a start byte address and a byte length. Both must be whole multiples of the configured page size, which need not be a power of two. The block turns the request into a page index and a page count with a shared serial divider. It then walks the range one command at a time. A command erases an eight-page block when the current page index is a multiple of eight and at least eight pages remain. Otherwise it erases a single page.

Each erase goes out as a four-byte frame. The frame carries the page index shifted left by a configurable amount, which lets the same logic serve parts with 256/264, 512/528 or 1024/1056 byte pages. After every erase the block polls the device status byte until its ready bit is set. A programmable idle gap separates unsuccessful polls. A cycle counter aborts the request with an error if the device stays busy too long. The bit-level shifter is outside the block: each byte is presented with a valid flag and is consumed when the master pulses a byte-done strobe. That strobe also returns the byte clocked in.

Top module: `spi_flash_eraser`

## Requirements
- R1: If the start address or the length is not a whole multiple of `page_size`, the request ends with a one-cycle `error` pulse. No SPI frame is issued and `done` stays low.
- R2: The opcode byte is 0x50 (block erase, eight pages) when the current page index has its three low bits equal to zero and at least eight pages remain. Otherwise it is 0x81 (single page erase).
- R3: An erase frame is exactly four bytes sent in this order: opcode, bits 23:16 of (page index << `page_shift`), bits 15:8 of the same value, then 0x00. `spi_tx_valid` is only high while `spi_cs` is high, and a presented byte is held until `spi_byte_done`.
- R4: After each erase frame, the block sends status frames of two bytes each: 0xD7 then 0x00. The byte returned with the second byte's strobe is the status. The device is ready when bit 7 of that status is 1, and only bit 7 is examined. Polling repeats until the device is ready.
- R5: When the device reports ready, the page index advances and the remaining page count drops. The step is eight pages after a block erase and one page after a page erase. The next erase frame uses the new index.
- R6: `spi_cs` is low between frames. The low time is exactly one cycle after an erase frame and after a ready poll. It is exactly `poll_gap`+1 cycles after a poll that reported busy.
- R7: The busy-wait after an erase is timed from the end of the erase frame. If `timeout_limit` or more cycles have passed when another poll would start, the request ends with a one-cycle `error` pulse and no `done`.
- R8: After reset, `busy`, `done`, `error` and `spi_cs` are low. When the last erase is confirmed ready, `done` pulses for one cycle, one cycle after `spi_cs` falls. A zero length gives `done` with no frames. `busy` is high from the cycle after `start` is taken and falls in the cycle in which `done` or `error` pulses.
- R9: Page size and page shift are independent inputs. Non-power-of-two page sizes (264, 528, 1056) are divided exactly when the page index is formed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken when idle |
| start_addr | input | AW | Start byte address |
| erase_len | input | AW | Length in bytes |
| page_size | input | PSW | Bytes per page, nonzero |
| page_shift | input | 4 | Left shift of the page index in the frame address |
| poll_gap | input | GW | Extra idle cycles after a busy status poll |
| timeout_limit | input | TW | Cycle limit on a single busy wait |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle failure pulse (misalignment or timeout) |
| spi_cs | output | 1 | Chip select, high during a frame |
| spi_tx_valid | output | 1 | Byte presented to the SPI master |
| spi_tx_byte | output | 8 | Byte to send |
| spi_byte_done | input | 1 | Master strobe: byte exchanged |
| spi_rx_byte | input | 8 | Byte received during the exchange |

## Verification
The assertions assume that `spi_byte_done` pulses only while `spi_tx_valid` is high and never for two cycles in a row. They also assume that the configuration inputs hold still while `busy` is high and that `page_size` is nonzero. The bench's byte responder raises the strobe only for a presented byte and only for a single cycle, after a fixed wait. Configuration and request inputs change only on falling edges between requests, once the previous `done` or `error` has been seen. Status bytes use all-ones for the non-ready bits, so a design that looks past bit 7 would misbehave.

// File: rtl/spi_flash_eraser.sv
module spi_flash_eraser #(
  parameter int AW  = 24,
  parameter int PSW = 12,
  parameter int GW  = 8,
  parameter int TW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  start_addr,
  input  logic [AW-1:0]  erase_len,
  input  logic [PSW-1:0] page_size,
  input  logic [3:0]     page_shift,
  input  logic [GW-1:0]  poll_gap,
  input  logic [TW-1:0]  timeout_limit,
  output logic           busy,
  output logic           done,
  output logic           error,
  output logic           spi_cs,
  output logic           spi_tx_valid,
  output logic [7:0]     spi_tx_byte,
  input  logic           spi_byte_done,
  input  logic [7:0]     spi_rx_byte
);
  localparam int CW  = $clog2(AW);
  localparam int SAW = AW + 16;
  localparam logic [7:0] OP_BLK  = 8'h50;
  localparam logic [7:0] OP_PAGE = 8'h81;
  localparam logic [7:0] OP_STAT = 8'hD7;

  typedef enum logic [2:0] {S_IDLE, S_DIVA, S_DIVL, S_CMD, S_GAP, S_POLL, S_NEXT} st_t;
  st_t st;

  logic [AW-1:0] dvd, rem, quot, len_q, pidx, npg;
  logic [CW-1:0] bitc;
  logic          bad;
  logic [1:0]    bidx;
  logic [GW-1:0] gcnt;
  logic [TW-1:0] tocnt;

  logic [AW:0]   trial, psz_ext;
  logic          ge, last, blk, ready;
  logic [AW-1:0] rem_n, quot_n, step;
  logic [7:0]    a_hi, a_mid;

  assign psz_ext = (AW+1)'(page_size);
  assign trial   = {rem, dvd[AW-1]};
  assign ge      = trial >= psz_ext;
  assign rem_n   = ge ? AW'(trial - psz_ext) : trial[AW-1:0];
  assign quot_n  = {quot[AW-2:0], ge};
  assign last    = bitc == CW'(AW-1);

  assign blk   = (pidx[2:0] == 3'd0) && (npg >= AW'(8));
  assign step  = blk ? AW'(8) : AW'(1);
  assign a_hi  = 8'((SAW'(pidx) << page_shift) >> 16);
  assign a_mid = 8'((SAW'(pidx) << page_shift) >> 8);
  assign ready = spi_rx_byte >= 8'h80;

  assign busy         = st != S_IDLE;
  assign spi_cs       = (st == S_CMD) || (st == S_POLL);
  assign spi_tx_valid = spi_cs;

  always_comb begin
    spi_tx_byte = 8'h00;
    if (st == S_CMD) begin
      case (bidx)
        2'd0:    spi_tx_byte = blk ? OP_BLK : OP_PAGE;
        2'd1:    spi_tx_byte = a_hi;
        2'd2:    spi_tx_byte = a_mid;
        default: spi_tx_byte = 8'h00;
      endcase
    end else if (st == S_POLL && bidx == 2'd0) begin
      spi_tx_byte = OP_STAT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      dvd <= '0; rem <= '0; quot <= '0; len_q <= '0;
      pidx <= '0; npg <= '0; bitc <= '0; bad <= 1'b0;
      bidx <= '0; gcnt <= '0; tocnt <= '0;
      done <= 1'b0; error <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          dvd <= start_addr; len_q <= erase_len;
          rem <= '0; quot <= '0; bitc <= '0; bad <= 1'b0;
          st <= S_DIVA;
        end
        S_DIVA: begin
          dvd <= dvd << 1; rem <= rem_n; quot <= quot_n; bitc <= bitc + 1'b1;
          if (last) begin
            pidx <= quot_n; bad <= rem_n != '0;
            dvd <= len_q; rem <= '0; quot <= '0; bitc <= '0;
            st <= S_DIVL;
          end
        end
        S_DIVL: begin
          dvd <= dvd << 1; rem <= rem_n; quot <= quot_n; bitc <= bitc + 1'b1;
          if (last) begin
            npg <= quot_n;
            bidx <= '0;
            if (bad || rem_n != '0) begin
              error <= 1'b1; st <= S_IDLE;
            end else if (quot_n == '0) begin
              done <= 1'b1; st <= S_IDLE;
            end else begin
              st <= S_CMD;
            end
          end
        end
        S_CMD: if (spi_byte_done) begin
          if (bidx == 2'd3) begin
            st <= S_GAP; gcnt <= '0; tocnt <= '0;
          end else begin
            bidx <= bidx + 1'b1;
          end
        end
        S_GAP: begin
          if (tocnt != '1) tocnt <= tocnt + 1'b1;
          if (gcnt == '0) begin
            if (tocnt >= timeout_limit) begin
              error <= 1'b1; st <= S_IDLE;
            end else begin
              bidx <= '0; st <= S_POLL;
            end
          end else begin
            gcnt <= gcnt - 1'b1;
          end
        end
        S_POLL: begin
          if (tocnt != '1) tocnt <= tocnt + 1'b1;
          if (spi_byte_done) begin
            if (bidx == 2'd0) begin
              bidx <= 2'd1;
            end else if (ready) begin
              pidx <= pidx + step; npg <= npg - step; st <= S_NEXT;
            end else begin
              gcnt <= poll_gap; st <= S_GAP;
            end
          end
        end
        S_NEXT: begin
          bidx <= '0;
          if (npg == '0) begin
            done <= 1'b1; st <= S_IDLE;
          end else begin
            st <= S_CMD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eraser_checks.sv
module eraser_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       error,
  input logic       spi_cs,
  input logic       spi_tx_valid,
  input logic [7:0] spi_tx_byte,
  input logic       spi_byte_done
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_error_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error);
  assert_done_error_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  assert_tx_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_valid |-> spi_cs);
  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_tx_valid && !spi_byte_done) |=> (spi_tx_valid && $stable(spi_tx_byte)));
  assert_cs_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs |-> busy);
  assert_end_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> (!busy && !spi_cs));
endmodule

bind spi_flash_eraser eraser_checks u_chk (.*);

// File: tb/sim_spi_flash_eraser.sv
module sim_spi_flash_eraser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0, erase_len = '0;
  logic [11:0] page_size = 12'd264;
  logic [3:0]  page_shift = 4'd9;
  logic [7:0]  poll_gap = 8'd0;
  logic [15:0] timeout_limit = 16'd1000;
  logic        busy, done, error, spi_cs, spi_tx_valid;
  logic [7:0]  spi_tx_byte;
  logic        spi_byte_done = 1'b0;
  logic [7:0]  spi_rx_byte = 8'h00;

  spi_flash_eraser u0 (.*);

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [7:0] xb_q[$];
  string      xt_q[$];
  int         xl_q[$];
  int  k_busy = 0;
  bit  forever_poll = 0;
  bit  active = 0;
  int  nfr = 0, gd = 0, ge = 0;
  bit  finished = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  task automatic push(logic [7:0] b, string t);
    xb_q.push_back(b); xt_q.push_back(t);
  endtask

  task automatic build(int a, int l, int ps, int sh, int k);
    int p, n, ad;
    bit blk, first;
    xb_q.delete(); xt_q.delete(); xl_q.delete();
    forever_poll = 0;
    if ((a % ps) != 0 || (l % ps) != 0) return;
    p = a / ps; n = l / ps; first = 1;
    while (n > 0) begin
      blk = ((p % 8) == 0) && (n >= 8);
      push(blk ? 8'h50 : 8'h81, "R2");
      ad = p << sh;
      push(8'((ad >> 16) & 255), first ? "R3" : "R5");
      push(8'((ad >> 8) & 255), first ? "R3" : "R5");
      push(8'h00, "R3");
      xl_q.push_back(4);
      if (k < 0) begin forever_poll = 1; break; end
      for (int j = 0; j <= k; j++) begin
        push(8'hD7, "R4"); push(8'h00, "R4"); xl_q.push_back(2);
      end
      p += blk ? 8 : 1; n -= blk ? 8 : 1; first = 0;
    end
  endtask

  // Byte responder, frame monitor and reference comparison, every clock
  int  lat = 0, fbytes = 0, lowcnt = 0, pollcnt = 0;
  bit  pcs = 0, in_poll = 0, prev_nr = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      summary();
    end
    if (!active) chk(!(spi_cs || busy), "R8", {spi_cs, busy}, 0);
    chk(!(done && error), "R8", {done, error}, 0);
    if (spi_cs && !pcs) begin
      if (nfr > 0) chk(lowcnt == (prev_nr ? int'(poll_gap) + 1 : 1), "R6", lowcnt,
                       prev_nr ? int'(poll_gap) + 1 : 1);
      fbytes = 0; nfr++;
    end
    if (!spi_cs && pcs) begin
      int el;
      el = (xl_q.size() > 0) ? xl_q.pop_front() : (forever_poll ? 2 : 0);
      chk(fbytes == el, in_poll ? "R4" : "R3", fbytes, el);
    end
    if (done || error) begin
      if (done) begin
        gd++;
        chk(xb_q.size() == 0, "R5", xb_q.size(), 0);
        if (nfr > 0) chk(lowcnt == 1, "R8", lowcnt, 1);
      end else ge++;
      chk(!busy, "R8", busy, 0);
      active = 0;
    end
    if (spi_byte_done) begin
      spi_byte_done = 0; lat = 0;
    end else if (spi_tx_valid) begin
      if (lat == 2) begin
        logic [7:0] eb; string et;
        bit rdy;
        if (fbytes == 0) begin
          in_poll = spi_tx_byte == 8'hD7;
          if (!in_poll) begin pollcnt = 0; prev_nr = 0; end
        end
        if (xb_q.size() > 0) begin eb = xb_q.pop_front(); et = xt_q.pop_front(); end
        else if (forever_poll) begin eb = (fbytes == 0) ? 8'hD7 : 8'h00; et = "R4"; end
        else begin eb = 8'hxx; et = "R3"; end
        chk(spi_tx_byte === eb, et, spi_tx_byte, eb);
        rdy = 0;
        if (in_poll && fbytes == 1) begin
          rdy = (k_busy >= 0) && (pollcnt >= k_busy);
          pollcnt++;
          prev_nr = !rdy;
        end
        spi_rx_byte = rdy ? 8'hA5 : 8'h7F;
        fbytes++;
        spi_byte_done = 1; lat = 0;
      end else lat++;
    end
    if (!spi_cs) lowcnt++; else lowcnt = 0;
    pcs = spi_cs;
  end

  task automatic run(int a, int l, int ps, int sh, int k, int g, int t, bit xerr, string tag);
    build(a, l, ps, sh, k);
    k_busy = k;
    @(negedge clk);
    start_addr = 24'(a); erase_len = 24'(l);
    page_size = 12'(ps); page_shift = 4'(sh);
    poll_gap = 8'(g); timeout_limit = 16'(t);
    nfr = 0; gd = 0; ge = 0; prev_nr = 0;
    active = 1; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 40000; i++) begin
      @(posedge clk);
      if (gd != 0 || ge != 0) break;
    end
    @(negedge clk);
    chk(ge == int'(xerr), tag, ge, int'(xerr));
    chk(gd == int'(!xerr), tag, gd, int'(!xerr));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error && !spi_cs, "R8", {busy, done, error, spi_cs}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // single block erase at page 0, immediate ready
    run(0, 8*264, 264, 9, 0, 0, 1000, 0, "R2");
    // pages 3..15: five page erases then one block, busy twice per erase
    run(3*264, 13*264, 264, 9, 2, 3, 1000, 0, "R5");
    // binary page size with same shift: block at 16, page at 24
    run(16*512, 9*512, 512, 9, 1, 0, 1000, 0, "R9");
    // large page size, high address bytes nonzero
    run(5000*1056, 1056, 1056, 11, 1, 2, 1000, 0, "R9");
    // 528-byte pages, shift 10, unaligned index so block not chosen until index 8
    run(6*528, 10*528, 528, 10, 0, 1, 1000, 0, "R2");
    // misaligned address and misaligned length
    run(100, 2*264, 264, 9, 0, 0, 1000, 1, "R1");
    chk(nfr == 0, "R1", nfr, 0);
    run(264, 2*264 + 1, 264, 9, 0, 0, 1000, 1, "R1");
    chk(nfr == 0, "R1", nfr, 0);
    // zero length
    run(8*264, 0, 264, 9, 0, 0, 1000, 0, "R8");
    chk(nfr == 0, "R8", nfr, 0);
    // device never ready: timeout
    run(2*264, 264, 264, 9, -1, 5, 60, 1, "R7");
    chk(nfr >= 3, "R7", nfr, 3);
    // long busy but within limit
    run(0, 264, 264, 9, 6, 4, 2000, 0, "R7");
    summary();
  end
endmodule